// File: doc/BRIEF.md
# Four-Bit Bidirectional Port with Pull-Up Control

This block is one general-purpose I/O port of `WIDTH` bits (four by default). Software-side logic writes three registers through a single write port: an output data latch, a per-bit direction register, and a per-bit pull-up enable register. The block turns these into the three pad-control signals of each bit (output enable, output value, pull-up enable) and brings the pad level back in through a two-flop synchronizer.

A read returns, bit by bit, either the data latch (for a bit set as output) or the synchronized pad level (for a bit set as input). Whenever a bit is an output, its pull-up is switched off no matter what its enable bit holds. The `OPEN_DRAIN` parameter selects a variant in which an output bit can only pull low and the pull-up register and its logic are not built at all.

Top module: `pio_port`

## Requirements
- R1: While and after reset the direction, latch and pull-up registers are all 0, so `pad_oe` and `pad_pu_en` are 0 and every bit reads as an input.
- R2: With `wr_en` high at a rising edge, `wr_sel` 2'b00 loads the latch, 2'b01 the direction register (1 = output), 2'b10 the pull-up register, each from `wr_data`; 2'b11 changes nothing. The new value is seen after that edge.
- R3: In the push-pull variant, an input bit drives `pad_pu_en` equal to its pull-up register bit.
- R4: An output bit drives `pad_pu_en` low whatever its pull-up register bit holds.
- R5: `rd_data` for an output bit equals its latch bit, independent of `pad_in`.
- R6: `rd_data` for an input bit equals the `pad_in` value sampled two rising edges earlier (two-flop synchronizer).
- R7: In the push-pull variant, `pad_oe` equals the direction register and `pad_out` equals the latch.
- R8: In the open-drain variant, `pad_oe` of a bit is high only when it is an output with latch 0, `pad_out` is always 0, and `pad_pu_en` is always 0 even after pull-up writes.
- R9: A latch written while a bit is an input leaves the pad undriven, and that value is driven once the bit becomes an output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 00 latch, 01 direction, 10 pull-up, 11 none |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Per-bit read-back: latch for outputs, synchronized pad for inputs |
| pad_in | input | WIDTH | Pad level seen by the port |
| pad_oe | output | WIDTH | Pad output enable |
| pad_out | output | WIDTH | Pad output value |
| pad_pu_en | output | WIDTH | Pad pull-up enable |

## Verification
The two functions that meet in one cycle are the direction change and the pad sampling: a bit flipping between input and output changes both its read source and its pull-up in the same cycle that the pad may be toggling. The bench provokes this by writing the direction register in the very cycle it changes `pad_in`, and again during a long run of random writes and random pad values. A behavioural model in the bench, holding its own register copies and a two-entry pad history, predicts all four outputs of a push-pull and an open-drain instance on every clock, so any misordered read source, pull-up, or synchronizer delay shows up as a mismatch on that cycle.

// File: rtl/pio_pkg.sv
package pio_pkg;
   typedef enum logic [1:0] {
      SEL_LATCH = 2'b00,
      SEL_DIR   = 2'b01,
      SEL_PULL  = 2'b10,
      SEL_NONE  = 2'b11
   } pio_sel_e;
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int WIDTH  = 4,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int CW = $clog2(STAGES + 1);

   if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
      $error("pio_sync: STAGES must be 2..4");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) chain[s] <= '0;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];

   // warm-up counter so the delay check never reaches into reset
   logic [CW-1:0] warm_q;
   always_ff @(posedge clk) begin
      if (!rst_n) warm_q <= '0;
      else if (warm_q != CW'(STAGES)) warm_q <= warm_q + 1'b1;
   end

   // R6
   sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == CW'(STAGES)) |-> (q == $past(d, STAGES)));
endmodule

// File: rtl/pio_regs.sv
module pio_regs
   import pio_pkg::*;
#(
   parameter int WIDTH    = 4,
   parameter bit HAS_PULL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  pio_sel_e         wr_sel,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] latch_q,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] pull_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) latch_q <= '0;
      else if (wr_en && wr_sel == SEL_LATCH) latch_q <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) dir_q <= '0;
      else if (wr_en && wr_sel == SEL_DIR) dir_q <= wr_data;
   end

   if (HAS_PULL) begin : g_pull
      always_ff @(posedge clk) begin
         if (!rst_n) pull_q <= '0;
         else if (wr_en && wr_sel == SEL_PULL) pull_q <= wr_data;
      end
   end else begin : g_no_pull
      assign pull_q = '0;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (latch_q == '0 && dir_q == '0 && pull_q == '0));

   // R2
   latch_wr_keeps_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel != SEL_DIR) |=> $stable(dir_q));

   // R2
   idle_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_NONE) |=> ($stable(latch_q) && $stable(pull_q)));
endmodule

// File: rtl/pio_bit.sv
module pio_bit #(
   parameter bit OPEN_DRAIN = 1'b0
) (
   input  logic latch,
   input  logic dir,
   input  logic pull,
   input  logic pad_sync,
   output logic oe,
   output logic out,
   output logic pu,
   output logic rd
);
   if (OPEN_DRAIN) begin : g_od
      assign oe  = dir & ~latch;
      assign out = 1'b0;
   end else begin : g_pp
      assign oe  = dir;
      assign out = latch;
   end

   assign pu = pull & ~dir;
   assign rd = dir ? latch : pad_sync;
endmodule

// File: rtl/pio_port.sv
module pio_port #(
   parameter int WIDTH       = 4,
   parameter bit OPEN_DRAIN  = 1'b0,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] rd_data,
   input  logic [WIDTH-1:0] pad_in,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_pu_en
);
   import pio_pkg::*;

   localparam bit HAS_PULL = !OPEN_DRAIN;

   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("pio_port: WIDTH must be 1..32");
   end

   logic [WIDTH-1:0] latch_w, dir_w, pull_w, sync_w;

   pio_regs #(.WIDTH(WIDTH), .HAS_PULL(HAS_PULL)) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (pio_sel_e'(wr_sel)),
      .wr_data (wr_data),
      .latch_q (latch_w),
      .dir_q   (dir_w),
      .pull_q  (pull_w)
   );

   pio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (sync_w)
   );

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      pio_bit #(.OPEN_DRAIN(OPEN_DRAIN)) bit_i (
         .latch    (latch_w[b]),
         .dir      (dir_w[b]),
         .pull     (pull_w[b]),
         .pad_sync (sync_w[b]),
         .oe       (pad_oe[b]),
         .out      (pad_out[b]),
         .pu       (pad_pu_en[b]),
         .rd       (rd_data[b])
      );
   end

   // R4
   out_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pu_en & dir_w) == '0);

   // R5
   out_reads_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_data ^ latch_w) & dir_w) == '0);

   if (OPEN_DRAIN) begin : g_od_chk
      // R8
      od_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pad_oe & rd_data) == '0 && pad_pu_en == '0);
   end else begin : g_pp_chk
      // R7
      pp_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((rd_data ^ pad_out) & pad_oe) == '0);
      // R3
      pp_pull_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_sel == 2'b10 && dir_w == '0 && wr_data == '1) |=> (pad_pu_en == '1 || $changed(dir_w)));
   end
endmodule

// File: tb/pio_port_tb_top.sv
module pio_port_tb_top;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_sel = 2'b00;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] pad_in = '0;
   logic [W-1:0] rd_pp, oe_pp, out_pp, pu_pp;
   logic [W-1:0] rd_od, oe_od, out_od, pu_od;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pio_port #(.WIDTH(W), .OPEN_DRAIN(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_data(rd_pp), .pad_in(pad_in), .pad_oe(oe_pp), .pad_out(out_pp), .pad_pu_en(pu_pp));

   pio_port #(.WIDTH(W), .OPEN_DRAIN(1'b1)) dut_od_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_data(rd_od), .pad_in(pad_in), .pad_oe(oe_od), .pad_out(out_od), .pad_pu_en(pu_od));

   // behavioural reference model
   logic [W-1:0] m_latch, m_dir, m_pull;
   logic [W-1:0] hist [$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_latch = '0; m_dir = '0; m_pull = '0;
         hist = {4'b0000, 4'b0000};
      end else begin
         if (wr_en) begin
            case (wr_sel)
               2'b00: m_latch = wr_data;
               2'b01: m_dir   = wr_data;
               2'b10: m_pull  = wr_data;
               default: ;
            endcase
         end
         hist.push_back(pad_in);
         void'(hist.pop_front());
      end
   end

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [W-1:0] exp_rd();
      logic [W-1:0] pad2 = hist[0];
      return (m_dir & m_latch) | (~m_dir & pad2);
   endfunction

   // per-cycle comparison
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R5 R6 rd push-pull", rd_pp, exp_rd());
         chk("R7 oe push-pull", oe_pp, m_dir);
         chk("R7 out push-pull", out_pp, m_latch);
         chk("R3 R4 pull-up push-pull", pu_pp, m_pull & ~m_dir);
         chk("R5 R6 rd open-drain", rd_od, exp_rd());
         chk("R8 oe open-drain", oe_od, m_dir & ~m_latch);
         chk("R8 out open-drain", out_od, '0);
         chk("R8 pull-up open-drain", pu_od, '0);
      end
   end

   task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      pad_in = 4'b1010;
      repeat (3) @(negedge clk);
      // R1: state during reset
      chk("R1 oe in reset", oe_pp, '0);
      chk("R1 pull-up in reset", pu_pp, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 oe after reset", oe_pp | oe_od, '0);
      @(negedge clk);
      // R6: pad seen two edges after release
      chk("R6 rd input pad", rd_pp, 4'b1010);
      // R9: latch written while input stays off the pad
      wr(2'b00, 4'b0101);
      chk("R9 no drive while input", oe_pp, '0);
      wr(2'b10, 4'b1111);
      chk("R3 pull-up on inputs", pu_pp, 4'b1111);
      chk("R8 no pull-up open-drain", pu_od, '0);
      // direction change in the same cycle as a pad toggle
      pad_in = 4'b0110;
      wr(2'b01, 4'b0011);
      chk("R9 latch driven after dir", out_pp & oe_pp, 4'b0001);
      chk("R4 pull-up off for outputs", pu_pp, 4'b1100);
      chk("R8 open-drain drives low only", oe_od, 4'b0010);
      chk("R5 rd output bits", rd_pp[1:0], 2'b01);
      // R2: select 11 ignored
      wr(2'b11, 4'b1111);
      chk("R2 idle select oe", oe_pp, 4'b0011);
      chk("R2 idle select pull-up", pu_pp, 4'b1100);
      // random phase
      for (int i = 0; i < 400; i++) begin
         pad_in = W'($urandom);
         if ($urandom_range(0, 2) == 0) wr(2'($urandom), W'($urandom));
         else @(negedge clk);
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule